// File: doc/BRIEF.md
# Serial ADC Bring-Up Sequencer

After reset, an external 13-bit serial converter has to be calibrated and given an acquisition time before its samples can be trusted. This block runs that bring-up on its own once `start` is pulsed. It hands one command byte at a time to an external byte shift engine and waits for the engine's acknowledge before it moves on. The commands go in this order:

1. Start self-calibration.
2. Read status once. This reply is a throwaway.
3. Wait for the converter's end-of-conversion (EOC) rising edge, with a timeout.
4. Read status again.
5. Check the calibration-busy flag.
6. If calibration has finished, program the sample-and-hold acquisition time.

The FSM states, in order, are:

- IDLE
- CAL_ISSUE and CAL_WAIT: the calibrate command
- PRE_ISSUE and PRE_WAIT: the throwaway status read
- EOC_WAIT
- STAT_ISSUE and STAT_WAIT: the real status read
- EVAL
- ACQ_ISSUE and ACQ_WAIT: the acquisition-time command
- DONE

The transitions are:

- IDLE goes to CAL_ISSUE on `start`.
- Each ISSUE state lasts exactly one cycle and goes to its WAIT state.
- Each WAIT state advances on `xfer_ack`.
- EOC_WAIT goes to STAT_ISSUE when an edge has been seen or the timer expires.
- EVAL returns to IDLE with `error` if the busy flag is set, and otherwise goes to ACQ_ISSUE.
- DONE lasts one cycle and returns to IDLE.

A parameter selects the converter variant. The narrow one- and two-input variants need every opcode remapped before it is sent: the upper two bits are kept and the low nibble is moved up by two bit positions.

Top module: `adc_bringup_seq`

## Requirements
- R1: During and after reset, `xfer_req`, `done`, `error` and `timeout` are all low.
- R2: The first transfer after an accepted `start` carries the calibrate opcode 0x08 with `xfer_two`=0. The bytes returned for it have no effect.
- R3: The second transfer carries the status opcode 0x0C with `xfer_two`=1. Its reply is ignored, even when the reply shows the busy flag set.
- R4: After the second transfer, the third transfer (status 0x0C, two bytes) waits for a rising EOC edge. Any edge seen after the start was accepted counts, including one that arrives during the first two transfers.
- R5: If no edge arrives within `TIMEOUT_CYCLES` cycles of EOC_WAIT, `timeout` goes high and the sequence continues with the status read.
- R6: The status word is {first reply byte, bit 7 of the second reply byte}, which is 9 bits. If status bit 6 (which is bit 5 of the first byte) is 1, `error` goes high, no acquisition command is sent and `done` stays low.
- R7: The fourth transfer carries the acquisition opcode with `xfer_two`=0. The opcode depends on `acq_sel`: 00 gives 0x4E (10 clocks, the default), 01 gives 0x0E (6 clocks), 10 gives 0x8E (18 clocks) and 11 gives 0xCE (34 clocks). `acq_sel` is sampled only when `start` is accepted.
- R8: With `NARROW`=1, each opcode is sent as (op & 0xC0) | ((op & 0x0F) << 2). This gives 0x08→0x20, 0x0C→0x30, 0x4E→0x78, 0x0E→0x38, 0x8E→0xB8 and 0xCE→0xF8.
- R9: `done` is high for exactly one cycle, in the cycle after the final acknowledge. `error` and `timeout` stay high until the next accepted `start` clears them.
- R10: `start` has no effect while a sequence is running. An EOC edge that occurs while idle has no effect.
- R11: `xfer_req` is a one-cycle pulse. No new request is issued before the previous one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence (accepted in IDLE only) |
| acq_sel | input | 2 | Acquisition-time select, sampled at start |
| eoc | input | 1 | End-of-conversion from the converter, asynchronous |
| xfer_req | output | 1 | One-cycle request to the shift engine |
| xfer_cmd | output | 8 | Command byte for the requested transfer |
| xfer_two | output | 1 | 1 = two-byte transfer, 0 = one byte |
| xfer_ack | input | 1 | Shift engine finished; reply bytes valid |
| xfer_rx0 | input | 8 | First received byte |
| xfer_rx1 | input | 8 | Second received byte |
| done | output | 1 | One-cycle pulse: sequence completed |
| error | output | 1 | Calibration still busy at the check |
| timeout | output | 1 | EOC wait expired |

## Verification
The wide and narrow variants are driven in lockstep from the same stimulus. Every run therefore compares the raw opcodes with their remapped forms.

Each of the four acquisition selects is run once with a clean status, which tells apart the opcode mapping. Three EOC timings are used: late, early (during the calibrate transfer) and absent. These separate edge latching from plain waiting and from timeout fall-through.

Status replies with a 1 in first-byte bit 5, first-byte bit 6 and second-byte bit 7 show whether the busy bit is taken from the correct position after the shift. A second `start` in mid-run shows that the select is sampled only once. An EOC pulse while idle shows that idle edges are not remembered.

// File: rtl/adc_bringup_pkg.sv
package adc_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAL_ISSUE,
        ST_CAL_WAIT,
        ST_PRE_ISSUE,
        ST_PRE_WAIT,
        ST_EOC_WAIT,
        ST_STAT_ISSUE,
        ST_STAT_WAIT,
        ST_EVAL,
        ST_ACQ_ISSUE,
        ST_ACQ_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_CAL,
        CK_STAT,
        CK_ACQ
    } cmd_kind_e;

    localparam logic [7:0] OP_CALIBRATE = 8'h08;
    localparam logic [7:0] OP_STATUS    = 8'h0C;
    localparam int         STAT_W       = 9;
    localparam int         BUSY_BIT     = 6;

    // Select 00 is the 10-clock default.
    function automatic logic [7:0] acq_opcode(input logic [1:0] sel);
        logic [7:0] op;
        unique case (sel)
            2'b00:   op = 8'h4E;
            2'b01:   op = 8'h0E;
            2'b10:   op = 8'h8E;
            default: op = 8'hCE;
        endcase
        return op;
    endfunction

    // Narrow variants drop the two unused mux bits of the low nibble.
    function automatic logic [7:0] narrow_remap(input logic [7:0] op);
        return (op & 8'hC0) | {op[3:0], 2'b00};
    endfunction

    function automatic logic [STAT_W-1:0] status_word(input logic [7:0] b0,
                                                      input logic [7:0] b1);
        return {b0, b1[7]};
    endfunction

endpackage

// File: rtl/adc_cmd_former.sv
module adc_cmd_former
    import adc_bringup_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  cmd_kind_e  kind,
    input  logic [1:0] sel,
    output logic [7:0] cmd
);

    logic [7:0] raw_op;

    always_comb begin
        unique case (kind)
            CK_CAL:  raw_op = OP_CALIBRATE;
            CK_STAT: raw_op = OP_STATUS;
            CK_ACQ:  raw_op = acq_opcode(sel);
            default: raw_op = OP_STATUS;
        endcase
    end

    generate
        if (NARROW) begin : g_narrow
            assign cmd = narrow_remap(raw_op);
        end else begin : g_wide
            assign cmd = raw_op;
        end
    endgenerate

endmodule

// File: rtl/adc_eoc_watch.sv
module adc_eoc_watch #(
    parameter int TIMEOUT_CYCLES = 12_500_000,
    parameter int SYNC_STAGES    = 2,
    localparam int TW            = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,    // start accepted: forget any earlier edge
    input  logic arm,      // sequence active: edges are recorded
    input  logic wait_en,  // in the EOC wait: timer runs
    input  logic eoc_in,
    output logic seen,
    output logic expired
);

    logic [SYNC_STAGES:0] sync_chain;
    logic                 eoc_prev;
    logic                 rise;
    logic [TW-1:0]        wait_cnt;

    assign sync_chain[0] = eoc_in;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_chain[i+1] <= 1'b0;
                else        sync_chain[i+1] <= sync_chain[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) eoc_prev <= 1'b0;
        else        eoc_prev <= sync_chain[SYNC_STAGES];
    end

    assign rise = sync_chain[SYNC_STAGES] & ~eoc_prev;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) seen <= 1'b0;
        else if (arm && rise) seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !wait_en)               wait_cnt <= '0;
        else if (wait_cnt != TW'(TIMEOUT_CYCLES - 1)) wait_cnt <= wait_cnt + 1'b1;
    end

    assign expired = wait_en && (wait_cnt == TW'(TIMEOUT_CYCLES - 1));

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
    import adc_bringup_pkg::*;
#(
    parameter bit NARROW         = 1'b0,
    parameter int TIMEOUT_CYCLES = 12_500_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] acq_sel,
    input  logic       eoc,
    output logic       xfer_req,
    output logic [7:0] xfer_cmd,
    output logic       xfer_two,
    input  logic       xfer_ack,
    input  logic [7:0] xfer_rx0,
    input  logic [7:0] xfer_rx1,
    output logic       done,
    output logic       error,
    output logic       timeout
);

    seq_state_e          state, state_nx;
    cmd_kind_e           kind;
    logic [1:0]          sel_q;
    logic [STAT_W-1:0]   stat_q;
    logic                error_q, timeout_q;
    logic                start_acc;
    logic                eoc_seen, eoc_expired;

    assign start_acc = (state == ST_IDLE) && start;

    adc_eoc_watch #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_eoc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_acc),
        .arm    (state != ST_IDLE),
        .wait_en(state == ST_EOC_WAIT),
        .eoc_in (eoc),
        .seen   (eoc_seen),
        .expired(eoc_expired)
    );

    adc_cmd_former #(.NARROW(NARROW)) u_cmd (
        .kind(kind),
        .sel (sel_q),
        .cmd (xfer_cmd)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start)    state_nx = ST_CAL_ISSUE;
            ST_CAL_ISSUE:                state_nx = ST_CAL_WAIT;
            ST_CAL_WAIT:   if (xfer_ack) state_nx = ST_PRE_ISSUE;
            ST_PRE_ISSUE:                state_nx = ST_PRE_WAIT;
            ST_PRE_WAIT:   if (xfer_ack) state_nx = ST_EOC_WAIT;
            ST_EOC_WAIT:   if (eoc_seen || eoc_expired) state_nx = ST_STAT_ISSUE;
            ST_STAT_ISSUE:               state_nx = ST_STAT_WAIT;
            ST_STAT_WAIT:  if (xfer_ack) state_nx = ST_EVAL;
            ST_EVAL:       state_nx = stat_q[BUSY_BIT] ? ST_IDLE : ST_ACQ_ISSUE;
            ST_ACQ_ISSUE:                state_nx = ST_ACQ_WAIT;
            ST_ACQ_WAIT:   if (xfer_ack) state_nx = ST_DONE;
            ST_DONE:                     state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // Sequence data: select, status capture, sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 2'b00;
            stat_q    <= '0;
            error_q   <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            if (start_acc) begin
                sel_q     <= acq_sel;
                error_q   <= 1'b0;
                timeout_q <= 1'b0;
            end
            if (state == ST_EOC_WAIT && !eoc_seen && eoc_expired)
                timeout_q <= 1'b1;
            if (state == ST_STAT_WAIT && xfer_ack)
                stat_q <= status_word(xfer_rx0, xfer_rx1);
            if (state == ST_EVAL && stat_q[BUSY_BIT])
                error_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        xfer_req = 1'b0;
        xfer_two = 1'b0;
        kind     = CK_STAT;
        done     = 1'b0;
        unique case (state)
            ST_CAL_ISSUE:  begin xfer_req = 1'b1; kind = CK_CAL;  end
            ST_PRE_ISSUE:  begin xfer_req = 1'b1; xfer_two = 1'b1; end
            ST_STAT_ISSUE: begin xfer_req = 1'b1; xfer_two = 1'b1; end
            ST_ACQ_ISSUE:  begin xfer_req = 1'b1; kind = CK_ACQ;  end
            ST_ACQ_WAIT:   kind = CK_ACQ;
            ST_CAL_WAIT:   kind = CK_CAL;
            ST_DONE:       done = 1'b1;
            default:       ;
        endcase
    end

    assign error   = error_q;
    assign timeout = timeout_q;

endmodule

// File: rtl/adc_bringup_chk.sv
module adc_bringup_chk #(
    parameter bit NARROW = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       xfer_req,
    input logic       xfer_ack,
    input logic [7:0] xfer_cmd,
    input logic       done,
    input logic       error,
    input logic       timeout
);

    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (xfer_req) pend <= 1'b1;
        else if (xfer_ack) pend <= 1'b0;
    end

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !pend);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_not_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !error);

    // R6
    halt_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |-> !xfer_req);

    // R9
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R9
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !start) |=> timeout);

    generate
        if (NARROW) begin : g_narrow
            // R8
            remap_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
                xfer_req |-> (xfer_cmd[1:0] == 2'b00 && xfer_cmd[5]));
        end else begin : g_wide
            // R8
            wide_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
                xfer_req |-> (xfer_cmd[3] && !xfer_cmd[0]));
        end
    endgenerate

endmodule

bind adc_bringup_seq adc_bringup_chk #(.NARROW(NARROW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .xfer_req(xfer_req),
    .xfer_ack(xfer_ack),
    .xfer_cmd(xfer_cmd),
    .done    (done),
    .error   (error),
    .timeout (timeout)
);

// File: tb/test_adc_bringup_seq.sv
`timescale 1ns/1ps

module xfer_engine_model (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       req,
    input  logic [7:0] cmd,
    input  logic       two,
    input  logic [7:0] stat0,
    input  logic [7:0] stat1,
    output logic       ack,
    output logic [7:0] rx0,
    output logic [7:0] rx1
);
    int         n = 0;
    int         overlap = 0;
    logic       pend = 1'b0;
    int         cnt = 0;
    int         idx = 0;
    logic [7:0] cmd_log [8];
    logic       two_log [8];

    initial begin
        ack = 1'b0;
        rx0 = 8'h00;
        rx1 = 8'h00;
    end

    always @(posedge clk) begin
        ack <= 1'b0;
        if (!rst_n || clr) begin
            n    <= 0;
            pend <= 1'b0;
        end else if (req) begin
            if (pend) overlap <= overlap + 1;
            if (n < 8) begin
                cmd_log[n] <= cmd;
                two_log[n] <= two;
            end
            idx  <= n;
            n    <= n + 1;
            pend <= 1'b1;
            cnt  <= 3;
        end else if (pend) begin
            if (cnt == 1) begin
                ack  <= 1'b1;
                pend <= 1'b0;
                rx0  <= (idx == 2) ? stat0 : 8'hFF;
                rx1  <= (idx == 2) ? stat1 : 8'hFF;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end
endmodule

module test_adc_bringup_seq;

    localparam int TMO = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] acq_sel = 2'b00;
    logic       eoc = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] stat0 = 8'h00, stat1 = 8'h00;

    logic       req_w, two_w, ack_w, done_w, err_w, tmo_w;
    logic [7:0] cmd_w, rx0_w, rx1_w;
    logic       req_n, two_n, ack_n, done_n, err_n, tmo_n;
    logic [7:0] cmd_n, rx0_n, rx1_n;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    adc_bringup_seq #(.NARROW(1'b0), .TIMEOUT_CYCLES(TMO)) i_adc_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .acq_sel(acq_sel), .eoc(eoc),
        .xfer_req(req_w), .xfer_cmd(cmd_w), .xfer_two(two_w), .xfer_ack(ack_w),
        .xfer_rx0(rx0_w), .xfer_rx1(rx1_w),
        .done(done_w), .error(err_w), .timeout(tmo_w));

    adc_bringup_seq #(.NARROW(1'b1), .TIMEOUT_CYCLES(TMO)) i_adc_bringup_seq_narrow (
        .clk(clk), .rst_n(rst_n), .start(start), .acq_sel(acq_sel), .eoc(eoc),
        .xfer_req(req_n), .xfer_cmd(cmd_n), .xfer_two(two_n), .xfer_ack(ack_n),
        .xfer_rx0(rx0_n), .xfer_rx1(rx1_n),
        .done(done_n), .error(err_n), .timeout(tmo_n));

    xfer_engine_model m_w (.clk(clk), .rst_n(rst_n), .clr(clr), .req(req_w),
        .cmd(cmd_w), .two(two_w), .stat0(stat0), .stat1(stat1),
        .ack(ack_w), .rx0(rx0_w), .rx1(rx1_w));

    xfer_engine_model m_n (.clk(clk), .rst_n(rst_n), .clr(clr), .req(req_n),
        .cmd(cmd_n), .two(two_n), .stat0(stat0), .stat1(stat1),
        .ack(ack_n), .rx0(rx0_n), .rx1(rx1_n));

    task automatic check(input string what, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", what, act, exp);
        end
    endtask

    function automatic int exp_op(input bit narrow, input int step, input logic [1:0] sel);
        if (step == 0) return narrow ? 'h20 : 'h08;
        if (step < 3)  return narrow ? 'h30 : 'h0C;
        case (sel)
            2'b00:   return narrow ? 'h78 : 'h4E;
            2'b01:   return narrow ? 'h38 : 'h0E;
            2'b10:   return narrow ? 'hB8 : 'h8E;
            default: return narrow ? 'hF8 : 'hCE;
        endcase
    endfunction

    // Runs one sequence on both variants. eoc_at < 0: no EOC pulse.
    // restart_at >= 0: a second start (with select 2'b11) is pulsed mid-run.
    task automatic run_seq(input logic [1:0] sel, input logic [7:0] s0, input logic [7:0] s1,
                           input int eoc_at, input int restart_at,
                           output int ndone, output bit got_err, output bit got_tmo);
        ndone = 0;
        stat0 = s0;
        stat1 = s1;
        @(negedge clk);
        start = 1'b1; clr = 1'b1; acq_sel = sel;
        @(negedge clk);
        start = 1'b0; clr = 1'b0;
        check("R9 error cleared by start", int'(err_w), 0);
        check("R9 timeout cleared by start", int'(tmo_w), 0);
        if (eoc_at >= 0) begin
            fork
                begin
                    repeat (eoc_at) @(negedge clk);
                    eoc = 1'b1;
                    repeat (4) @(negedge clk);
                    eoc = 1'b0;
                end
            join_none
        end
        if (restart_at >= 0) begin
            fork
                begin
                    repeat (restart_at) @(negedge clk);
                    start = 1'b1; acq_sel = 2'b11;
                    @(negedge clk);
                    start = 1'b0; acq_sel = sel;
                end
            join_none
        end
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done_w) ndone++;
            if (done_w || err_w) break;
        end
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done_w) ndone++;
        end
        got_err = err_w;
        got_tmo = tmo_w;
        check("R8 variants agree on done/error", int'({done_n, err_n, tmo_n}),
              int'({done_w, err_w, tmo_w}));
    endtask

    task automatic check_log(input string tag, input logic [1:0] sel, input bit with_acq);
        int nexp;
        nexp = with_acq ? 4 : 3;
        check({tag, " R6/R7 transfer count"}, m_w.n, nexp);
        check({tag, " R8 narrow transfer count"}, m_n.n, nexp);
        for (int i = 0; i < nexp; i++) begin
            check({tag, (i == 0) ? " R2 cal op" : (i < 3) ? " R3/R4 status op" : " R7 acq op"},
                  int'(m_w.cmd_log[i]), exp_op(1'b0, i, sel));
            check({tag, " R8 remapped op"}, int'(m_n.cmd_log[i]), exp_op(1'b1, i, sel));
            check({tag, " R2/R3 transfer length"}, int'(m_w.two_log[i]),
                  (i == 1 || i == 2) ? 1 : 0);
        end
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R1 outputs low in reset", int'({req_w, done_w, err_w, tmo_w}), 0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 outputs low after reset", int'({req_w, done_w, err_w, tmo_w}), 0);
        check("R1 narrow outputs low", int'({req_n, done_n, err_n, tmo_n}), 0);
    endtask

    task automatic t_all_selects;
        int nd; bit e, t;
        for (int s = 0; s < 4; s++) begin
            run_seq(2'(s), 8'h00, 8'h00, 40, -1, nd, e, t);
            check("R9 done single cycle", nd, 1);
            check("R6 no error on idle status", int'(e), 0);
            check("R4 no timeout with edge", int'(t), 0);
            check_log("sel", 2'(s), 1'b1);
        end
    endtask

    task automatic t_early_eoc;
        int nd; bit e, t;
        run_seq(2'b01, 8'h00, 8'h00, 1, -1, nd, e, t);
        check("R4 early edge remembered, no timeout", int'(t), 0);
        check("R4 early edge run completes", nd, 1);
        check_log("early", 2'b01, 1'b1);
    endtask

    task automatic t_timeout;
        int nd; bit e, t;
        fork
            begin
                repeat (TMO / 2) @(negedge clk);
                check("R4 status read held back while waiting", m_w.n, 2);
            end
        join_none
        run_seq(2'b10, 8'h00, 8'h00, -1, -1, nd, e, t);
        check("R5 timeout raised", int'(t), 1);
        check("R5 sequence continues after timeout", nd, 1);
        check_log("timeout", 2'b10, 1'b1);
        repeat (5) @(negedge clk);
        check("R9 timeout held", int'(tmo_w), 1);
    endtask

    task automatic t_status_bits;
        int nd; bit e, t;
        run_seq(2'b00, 8'h20, 8'h00, 40, -1, nd, e, t);
        check("R6 busy bit gives error", int'(e), 1);
        check("R6 no done on busy", nd, 0);
        check_log("busy", 2'b00, 1'b0);
        repeat (10) @(negedge clk);
        check("R6 no request after error", m_w.n, 3);
        check("R9 error held", int'(err_w), 1);
        run_seq(2'b00, 8'h40, 8'h80, 40, -1, nd, e, t);
        check("R6 bits 7 and 0 are not busy", int'(e), 0);
        check("R6 completes when not busy", nd, 1);
        run_seq(2'b11, 8'hDF, 8'hFF, 40, -1, nd, e, t);
        check("R6 all other bits set is not busy", int'(e), 0);
        check_log("nbusy", 2'b11, 1'b1);
    endtask

    task automatic t_ignored_inputs;
        int nd; bit e, t;
        run_seq(2'b01, 8'h00, 8'h00, 40, 12, nd, e, t);
        check("R10 restart ignored, one done", nd, 1);
        check_log("restart R7 sel sampled once", 2'b01, 1'b1);
        @(negedge clk); eoc = 1'b1;
        repeat (4) @(negedge clk); eoc = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 idle EOC issues nothing", int'(req_w), 0);
        run_seq(2'b00, 8'h00, 8'h00, -1, -1, nd, e, t);
        check("R10 idle EOC not remembered", int'(t), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog R1-R11 act=hung exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset();
        t_all_selects();
        t_early_eoc();
        t_timeout();
        t_status_bits();
        t_ignored_inputs();
        check("R11 no overlapped request (wide)", m_w.overlap, 0);
        check("R11 no overlapped request (narrow)", m_n.overlap, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule